// File: doc/BRIEF.md
# PHY Power-Up Calibration and DLL Sequencer

This block is a hardware state machine that brings the analog front end of a storage-interface PHY up and down. A single power-on or power-off request pulse starts it. Each request first parks the PHY by pulling the power-down-bar line low and then dropping the DLL enable. A power-off request ends there. A power-on request goes on. It waits a settling time and raises power-down-bar. It then waits for the pad calibration to report completion, programs the DLL frequency band and enables the DLL. Last, it waits for the DLL to report lock. Each wait runs under its own timeout.

The measured card clock rate, an integer in Hz, is sampled when a request is accepted. It is mapped onto one of four DLL frequency bands. A warning flag is raised when the rate is far from the centre of its band or above the top band. When the rate is zero there is no clock to lock to, so the sequencer finishes right after it enables the DLL. All waits count system clock cycles, and a parameter gives the number of cycles per microsecond. A power-on request also loads the pad drive-strength code and the output tap-delay settings.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, pdb, dllEn, freqSel, driveStrength, tapDlyEn, tapDlySel, busy, done, err, errCode and rateWarn are all 0.
- R2: An accepted request drives pdb low one cycle after acceptance and dllEn low one cycle later. A power-off request then gives a one-cycle done pulse in the cycle that follows the dllEn-low cycle.
- R3: Band codes on freqSel: rate 0 gives code 0. A nonzero rate below 75 000 000 gives code 1. A rate in [75 000 000, 125 000 000) gives code 2. A rate in [125 000 000, 175 000 000) gives code 3. A rate of 175 000 000 or more gives code 0.
- R4: rateWarn is latched at power-on acceptance. It is 1 when the rate exceeds 200 000 000. It is also 1 when the rate exceeds 50 000 000 and differs from its band target by more than 15 000 000. The band targets are 50, 100, 150 and 200 MHz for codes 1, 2, 3 and 0. A power-off request clears rateWarn.
- R5: During power-on, pdb rises SETTLE_US*CYC_PER_US cycles after the dllEn-low cycle, and never while dllEn is high.
- R6: If calDone stays low for CAL_US*CYC_PER_US cycles after pdb rises, the sequence stops. err goes to 1 with errCode 1, and no done pulse is given.
- R7: After calDone is seen, freqSel is written one cycle before dllEn rises. pdb is high when dllEn rises.
- R8: With a rate of 0, done pulses in the cycle after dllEn rises, without waiting for dllReady.
- R9: With a nonzero rate, done pulses one cycle after dllReady is seen. If dllReady stays low for LOCK_US*CYC_PER_US cycles, err goes to 1 with errCode 2 instead.
- R10: Power-on acceptance loads driveStrength from driveCode, sets tapDlyEn to 1 and sets tapDlySel to 4. A power-off request leaves all three unchanged.
- R11: busy is high from the cycle after acceptance until the sequence ends. Requests made while busy have no effect.
- R12: If reqOn and reqOff are both high in an idle cycle, the power-on sequence runs. A new request clears err and errCode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqOn | input | 1 | Power-on request pulse |
| reqOff | input | 1 | Power-off request pulse |
| rateHz | input | RATE_W | Measured card clock rate in Hz |
| driveCode | input | 3 | Configured pad drive-strength code |
| calDone | input | 1 | Pad calibration complete status |
| dllReady | input | 1 | DLL lock status |
| pdb | output | 1 | PHY power-down-bar |
| dllEn | output | 1 | DLL enable |
| freqSel | output | 2 | DLL frequency band code |
| driveStrength | output | 3 | Applied drive-strength code |
| tapDlyEn | output | 1 | Output tap delay enable |
| tapDlySel | output | 4 | Output tap delay select |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle successful completion pulse |
| err | output | 1 | Sequence stopped on a timeout |
| errCode | output | 2 | Failing phase: 1 calibration, 2 DLL lock |
| rateWarn | output | 1 | Rate off the band centre or above range |

## Verification
The bench drives rates that sit on every band edge: 74 999 999, 75 000 000, 124 999 999, 125 000 000 and 175 000 000. A design with an off-by-one compare would put one of these in the wrong band. It also drives rates just inside and just outside the 15 MHz warning margin, plus a rate of exactly 50 MHz. A wrong warning rule would flag a slow clock or miss a detuned one. Both timeouts are left to expire. A counter that is one cycle off would show up as err rising a cycle early or late. The zero-rate case checks that done arrives without dllReady, so a design that waits for lock would stall until its timeout. Requests are also injected while busy, together with a simultaneous on and off request. A design that accepts them would restart the sequence or drop the tap settings.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PDB_LO,
    S_DLL_LO,
    S_SETTLE,
    S_CAL_WAIT,
    S_FSEL,
    S_DLL_ON,
    S_LOCK_WAIT
  } seq_state_t;

  // Strobes from control to datapath, one bit per datapath action
  typedef struct packed {
    logic latchReq;
    logic applyOn;
    logic pdbLow;
    logic dllLow;
    logic loadSettle;
    logic pdbHigh;
    logic loadCal;
    logic selFreq;
    logic dllHigh;
    logic loadLock;
    logic dec;
    logic doneP;
    logic errCal;
    logic errLock;
  } seq_strobe_t;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_CAL  = 2'd1;
  localparam logic [1:0] ERR_LOCK = 2'd2;

  localparam logic [1:0] BAND_200M = 2'd0;
  localparam logic [1:0] BAND_50M  = 2'd1;
  localparam logic [1:0] BAND_100M = 2'd2;
  localparam logic [1:0] BAND_150M = 2'd3;

  localparam logic [3:0] TAP_SEL_INIT = 4'd4;

endpackage

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqOn,
  input  logic        reqOff,
  input  logic        calDone,
  input  logic        dllReady,
  input  logic        timerZero,
  input  logic        rateZero,
  output seq_strobe_t strb,
  output logic        busy
);

  seq_state_t state, nextState;
  logic offQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      offQ  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && (reqOn || reqOff)) offQ <= !reqOn;
    end
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (reqOn || reqOff) begin
          strb.latchReq = 1'b1;
          strb.applyOn  = reqOn;
          nextState     = S_PDB_LO;
        end
      end
      S_PDB_LO: begin
        strb.pdbLow = 1'b1;
        nextState   = S_DLL_LO;
      end
      S_DLL_LO: begin
        strb.dllLow = 1'b1;
        if (offQ) begin
          strb.doneP = 1'b1;
          nextState  = S_IDLE;
        end else begin
          strb.loadSettle = 1'b1;
          nextState       = S_SETTLE;
        end
      end
      S_SETTLE: begin
        if (timerZero) begin
          strb.pdbHigh = 1'b1;
          strb.loadCal = 1'b1;
          nextState    = S_CAL_WAIT;
        end else begin
          strb.dec = 1'b1;
        end
      end
      S_CAL_WAIT: begin
        if (calDone) begin
          nextState = S_FSEL;
        end else if (timerZero) begin
          strb.errCal = 1'b1;
          nextState   = S_IDLE;
        end else begin
          strb.dec = 1'b1;
        end
      end
      S_FSEL: begin
        strb.selFreq = 1'b1;
        nextState    = S_DLL_ON;
      end
      S_DLL_ON: begin
        strb.dllHigh = 1'b1;
        if (rateZero) begin
          strb.doneP = 1'b1;
          nextState  = S_IDLE;
        end else begin
          strb.loadLock = 1'b1;
          nextState     = S_LOCK_WAIT;
        end
      end
      S_LOCK_WAIT: begin
        if (dllReady) begin
          strb.doneP = 1'b1;
          nextState  = S_IDLE;
        end else if (timerZero) begin
          strb.errLock = 1'b1;
          nextState    = S_IDLE;
        end else begin
          strb.dec = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  AST_BUSY_HOLDS_KIND: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |=> $stable(offQ)); // R11

  AST_OFF_ENDS_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DLL_LO && offQ) |=> (state == S_IDLE)); // R2

  AST_CAL_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CAL_WAIT && !calDone && timerZero) |=> (state == S_IDLE)); // R6

endmodule

// File: rtl/phy_seq_dpath.sv
module phy_seq_dpath
  import phy_seq_pkg::*;
#(
  parameter int RATE_W     = 32,
  parameter int CYC_PER_US = 100,
  parameter int SETTLE_US  = 3,
  parameter int CAL_US     = 50,
  parameter int LOCK_US    = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strb,
  input  logic [RATE_W-1:0] rateHz,
  input  logic [2:0]        driveCode,
  output logic              timerZero,
  output logic              rateZero,
  output logic              pdb,
  output logic              dllEn,
  output logic [1:0]        freqSel,
  output logic [2:0]        driveStrength,
  output logic              tapDlyEn,
  output logic [3:0]        tapDlySel,
  output logic              done,
  output logic              err,
  output logic [1:0]        errCode,
  output logic              rateWarn
);

  localparam int SETTLE_CYC = (SETTLE_US * CYC_PER_US < 1) ? 1 : SETTLE_US * CYC_PER_US;
  localparam int CAL_CYC    = (CAL_US * CYC_PER_US < 1) ? 1 : CAL_US * CYC_PER_US;
  localparam int LOCK_CYC   = (LOCK_US * CYC_PER_US < 1) ? 1 : LOCK_US * CYC_PER_US;
  localparam int MAX_CYC    = (LOCK_CYC > CAL_CYC) ?
                              ((LOCK_CYC > SETTLE_CYC) ? LOCK_CYC : SETTLE_CYC) :
                              ((CAL_CYC > SETTLE_CYC) ? CAL_CYC : SETTLE_CYC);
  localparam int TMR_W      = $clog2(MAX_CYC + 1);

  localparam logic [RATE_W-1:0] HZ_15M  = RATE_W'(15_000_000);
  localparam logic [RATE_W-1:0] HZ_50M  = RATE_W'(50_000_000);
  localparam logic [RATE_W-1:0] HZ_75M  = RATE_W'(75_000_000);
  localparam logic [RATE_W-1:0] HZ_100M = RATE_W'(100_000_000);
  localparam logic [RATE_W-1:0] HZ_125M = RATE_W'(125_000_000);
  localparam logic [RATE_W-1:0] HZ_150M = RATE_W'(150_000_000);
  localparam logic [RATE_W-1:0] HZ_175M = RATE_W'(175_000_000);
  localparam logic [RATE_W-1:0] HZ_200M = RATE_W'(200_000_000);

  logic [TMR_W-1:0]  timer;
  logic [1:0]        bandNext, bandQ;
  logic [RATE_W-1:0] target, diff;
  logic              warnNext, rateZeroQ;

  // Band lookup on the live rate; it is latched when a request is accepted
  always_comb begin
    if (rateHz == '0) begin
      bandNext = BAND_200M;
      target   = HZ_200M;
    end else if (rateHz < HZ_75M) begin
      bandNext = BAND_50M;
      target   = HZ_50M;
    end else if (rateHz < HZ_125M) begin
      bandNext = BAND_100M;
      target   = HZ_100M;
    end else if (rateHz < HZ_175M) begin
      bandNext = BAND_150M;
      target   = HZ_150M;
    end else begin
      bandNext = BAND_200M;
      target   = HZ_200M;
    end
    diff     = (rateHz > target) ? (rateHz - target) : (target - rateHz);
    warnNext = ((rateHz > HZ_50M) && (diff > HZ_15M)) || (rateHz > HZ_200M);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strb.loadSettle) begin
      timer <= TMR_W'(SETTLE_CYC - 1);
    end else if (strb.loadCal) begin
      timer <= TMR_W'(CAL_CYC - 1);
    end else if (strb.loadLock) begin
      timer <= TMR_W'(LOCK_CYC - 1);
    end else if (strb.dec && timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  assign timerZero = (timer == '0);
  assign rateZero  = rateZeroQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bandQ         <= BAND_200M;
      rateZeroQ     <= 1'b0;
      rateWarn      <= 1'b0;
      driveStrength <= '0;
      tapDlyEn      <= 1'b0;
      tapDlySel     <= '0;
      pdb           <= 1'b0;
      dllEn         <= 1'b0;
      freqSel       <= BAND_200M;
      done          <= 1'b0;
      err           <= 1'b0;
      errCode       <= ERR_NONE;
    end else begin
      done <= strb.doneP;
      if (strb.latchReq) begin
        bandQ     <= bandNext;
        rateZeroQ <= (rateHz == '0);
        rateWarn  <= strb.applyOn & warnNext;
        err       <= 1'b0;
        errCode   <= ERR_NONE;
      end
      if (strb.applyOn) begin
        driveStrength <= driveCode;
        tapDlyEn      <= 1'b1;
        tapDlySel     <= TAP_SEL_INIT;
      end
      if (strb.pdbLow)  pdb     <= 1'b0;
      if (strb.pdbHigh) pdb     <= 1'b1;
      if (strb.dllLow)  dllEn   <= 1'b0;
      if (strb.dllHigh) dllEn   <= 1'b1;
      if (strb.selFreq) freqSel <= bandQ;
      if (strb.errCal) begin
        err     <= 1'b1;
        errCode <= ERR_CAL;
      end
      if (strb.errLock) begin
        err     <= 1'b1;
        errCode <= ERR_LOCK;
      end
    end
  end

  AST_PDB_UP_DLL_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdb) |-> !dllEn); // R5

  AST_DLL_UP_PDB_UP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dllEn) |-> pdb); // R7

  AST_DLL_UP_BAND_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dllEn) |-> (freqSel == bandQ)); // R7

  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !err); // R8

  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (errCode != ERR_NONE)); // R9

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_seq_pkg::*;
#(
  parameter int RATE_W     = 32,
  parameter int CYC_PER_US = 100,
  parameter int SETTLE_US  = 3,
  parameter int CAL_US     = 50,
  parameter int LOCK_US    = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqOn,
  input  logic              reqOff,
  input  logic [RATE_W-1:0] rateHz,
  input  logic [2:0]        driveCode,
  input  logic              calDone,
  input  logic              dllReady,
  output logic              pdb,
  output logic              dllEn,
  output logic [1:0]        freqSel,
  output logic [2:0]        driveStrength,
  output logic              tapDlyEn,
  output logic [3:0]        tapDlySel,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        errCode,
  output logic              rateWarn
);

  seq_strobe_t strb;
  logic timerZero, rateZero;

  phy_seq_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqOn     (reqOn),
    .reqOff    (reqOff),
    .calDone   (calDone),
    .dllReady  (dllReady),
    .timerZero (timerZero),
    .rateZero  (rateZero),
    .strb      (strb),
    .busy      (busy)
  );

  phy_seq_dpath #(
    .RATE_W     (RATE_W),
    .CYC_PER_US (CYC_PER_US),
    .SETTLE_US  (SETTLE_US),
    .CAL_US     (CAL_US),
    .LOCK_US    (LOCK_US)
  ) uDpath (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .rateHz        (rateHz),
    .driveCode     (driveCode),
    .timerZero     (timerZero),
    .rateZero      (rateZero),
    .pdb           (pdb),
    .dllEn         (dllEn),
    .freqSel       (freqSel),
    .driveStrength (driveStrength),
    .tapDlyEn      (tapDlyEn),
    .tapDlySel     (tapDlySel),
    .done          (done),
    .err           (err),
    .errCode       (errCode),
    .rateWarn      (rateWarn)
  );

endmodule

// File: tb/tb_phy_pwr_seq.sv
`timescale 1ns/1ps
module tb_phy_pwr_seq;

  localparam int CPU   = 2;
  localparam int SETUS = 3;
  localparam int CALUS = 50;
  localparam int LCKUS = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqOn = 1'b0, reqOff = 1'b0, calDone = 1'b0, dllReady = 1'b0;
  logic [31:0] rateHz = '0;
  logic [2:0]  driveCode = 3'd0;
  logic pdb, dllEn, tapDlyEn, busy, done, err, rateWarn;
  logic [1:0] freqSel, errCode;
  logic [2:0] driveStrength;
  logic [3:0] tapDlySel;

  always #5 clk = ~clk;

  phy_pwr_seq #(.RATE_W(32), .CYC_PER_US(CPU), .SETTLE_US(SETUS),
                .CAL_US(CALUS), .LOCK_US(LCKUS)) dut (
    .clk(clk), .rstN(rstN), .reqOn(reqOn), .reqOff(reqOff), .rateHz(rateHz),
    .driveCode(driveCode), .calDone(calDone), .dllReady(dllReady),
    .pdb(pdb), .dllEn(dllEn), .freqSel(freqSel), .driveStrength(driveStrength),
    .tapDlyEn(tapDlyEn), .tapDlySel(tapDlySel), .busy(busy), .done(done),
    .err(err), .errCode(errCode), .rateWarn(rateWarn));

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  // Behavioural reference: a phase number and a remaining-wait counter
  int  mPhase, mLeft;
  bit  mOff, mRateZero, mBandWarn;
  int  mBand;
  int  mPdb, mDll, mFsel, mDrv, mTapEn, mTapSel, mBusy, mDone, mErr, mCode, mWarn;

  function automatic int bandOf(longint r);
    if (r == 0) return 0;
    if (r < 75_000_000) return 1;
    if (r < 125_000_000) return 2;
    if (r < 175_000_000) return 3;
    return 0;
  endfunction

  function automatic bit warnOf(longint r);
    longint tgt, d;
    case (bandOf(r))
      1: tgt = 50_000_000;
      2: tgt = 100_000_000;
      3: tgt = 150_000_000;
      default: tgt = 200_000_000;
    endcase
    d = (r > tgt) ? r - tgt : tgt - r;
    return (r > 50_000_000 && d > 15_000_000) || (r > 200_000_000);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mLeft = 0; mOff = 0; mRateZero = 0; mBand = 0;
      mPdb = 0; mDll = 0; mFsel = 0; mDrv = 0; mTapEn = 0; mTapSel = 0;
      mDone = 0; mErr = 0; mCode = 0; mWarn = 0;
    end else begin
      mDone = 0;
      case (mPhase)
        0: if (reqOn || reqOff) begin
             mOff = !reqOn; mRateZero = (rateHz == 0); mBand = bandOf(rateHz);
             mWarn = reqOn ? warnOf(rateHz) : 0;
             mErr = 0; mCode = 0;
             if (reqOn) begin mDrv = driveCode; mTapEn = 1; mTapSel = 4; end
             mPhase = 1;
           end
        1: begin mPdb = 0; mPhase = 2; end
        2: begin
             mDll = 0;
             if (mOff) begin mDone = 1; mPhase = 0; end
             else begin mLeft = SETUS * CPU - 1; mPhase = 3; end
           end
        3: if (mLeft == 0) begin mPdb = 1; mLeft = CALUS * CPU - 1; mPhase = 4; end
           else mLeft--;
        4: if (calDone) mPhase = 5;
           else if (mLeft == 0) begin mErr = 1; mCode = 1; mPhase = 0; end
           else mLeft--;
        5: begin mFsel = mBand; mPhase = 6; end
        6: begin
             mDll = 1;
             if (mRateZero) begin mDone = 1; mPhase = 0; end
             else begin mLeft = LCKUS * CPU - 1; mPhase = 7; end
           end
        7: if (dllReady) begin mDone = 1; mPhase = 0; end
           else if (mLeft == 0) begin mErr = 1; mCode = 2; mPhase = 0; end
           else mLeft--;
        default: mPhase = 0;
      endcase
    end
    mBusy = (mPhase != 0);
  end

  task automatic cmp(input string tag, input int got, input int exp);
    if (got != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      vectors++;
      cmp("R2/R5 pdb", pdb, mPdb);
      cmp("R7/R9 dllEn", dllEn, mDll);
      cmp("R3/R7 freqSel", freqSel, mFsel);
      cmp("R10 driveStrength", driveStrength, mDrv);
      cmp("R10 tapDlyEn", tapDlyEn, mTapEn);
      cmp("R10 tapDlySel", tapDlySel, mTapSel);
      cmp("R11/R12 busy", busy, mBusy);
      cmp("R2/R8 done", done, mDone);
      cmp("R6/R9 err", err, mErr);
      cmp("R6/R9 errCode", errCode, mCode);
      cmp("R4 rateWarn", rateWarn, mWarn);
    end
  end

  // One request, then follow the sequence until the reference goes idle
  task automatic runReq(input longint rate, input bit on, input bit off,
                        input int calAt, input int lockAt, input int pokeAt);
    @(negedge clk);
    rateHz = rate[31:0]; reqOn = on; reqOff = off; calDone = 0; dllReady = 0;
    for (int c = 1; c < 2000; c++) begin
      @(negedge clk);
      reqOn  = (c == pokeAt);
      reqOff = (c == pokeAt);
      calDone  = (calAt >= 0 && c >= calAt);
      dllReady = (lockAt >= 0 && c >= lockAt);
      if (mPhase == 0 && c > pokeAt) break;
    end
    reqOn = 0; reqOff = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values, checked while reset is still held
    vectors++;
    if ({pdb, dllEn, freqSel, driveStrength, tapDlyEn, tapDlySel, busy, done, err, errCode, rateWarn} != '0) begin
      misses++;
      $display("FAIL R1 reset: actual %0h expected 0",
               {pdb, dllEn, freqSel, driveStrength, tapDlyEn, tapDlySel, busy, done, err, errCode, rateWarn});
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    driveCode = 3'd5;
    runReq(100_000_000, 1, 0, 20, 40, 0);   // R3 R5 R7 R9 R10 nominal lock
    runReq(0,           1, 0, 15, -1, 0);   // R8 no clock, no lock wait
    runReq(130_000_000, 1, 0, 3, 30, 0);    // R4 detuned warn, band 3
    runReq(210_000_000, 1, 0, 12, 25, 0);   // R4 above range
    runReq(74_999_999,  1, 0, 12, 25, 0);   // R3 edge
    runReq(75_000_000,  1, 0, 12, 25, 0);   // R3 edge
    runReq(124_999_999, 1, 0, 12, 25, 0);   // R3 edge
    runReq(125_000_000, 1, 0, 12, 25, 0);   // R3 edge
    runReq(175_000_000, 1, 0, 12, 25, 0);   // R3 top band
    runReq(50_000_000,  1, 0, 12, 25, 0);   // R4 no warn at 50 MHz
    runReq(64_000_000,  1, 0, 12, 25, 0);   // R4 margin 14 MHz
    runReq(66_000_000,  1, 0, 12, 25, 0);   // R4 margin 16 MHz
    runReq(30_000_000,  1, 0, -1, -1, 0);   // R6 calibration timeout
    driveCode = 3'd2;
    runReq(150_000_000, 1, 0, 12, -1, 0);   // R9 lock timeout
    runReq(100_000_000, 0, 1, -1, -1, 0);   // R2 R10 power-off keeps taps
    runReq(80_000_000,  1, 0, 20, 60, 5);   // R11 requests while busy ignored
    driveCode = 3'd7;
    runReq(140_000_000, 1, 1, 10, 30, 0);   // R12 on wins over off
    runReq(90_000_000,  0, 1, -1, -1, 3);   // R11 poke during power-off

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule